// File: doc/BRIEF.md
# Branch Condition and Loop Resolver

This block decides whether a control transfer is taken and which instruction pointer follows it. A request carries an operation code, the four arithmetic flags (sign, zero, overflow, carry), the current value of the count register, the branch target and the fall-through address. The block answers with a taken bit, the next instruction pointer, and for counted loops the decremented count together with a write-enable for the count register.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, one result per request, in order. A single output register sits between them. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high, and its result is presented from the next cycle on. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is taken. A producer must keep a request's fields stable until it is accepted.

The flag-test operations cover signed and unsigned comparisons, which are built from XOR and OR combinations of the flags. The loop operations always decrement the count first. They then branch on the new count, and two of them also qualify the branch with the zero flag.

Top module: `br_resolve`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted at one edge produces `out_valid`=1 from the next cycle on. While `out_valid`=1 and `out_ready`=0, every output holds its value and `in_ready`=0, so no request is taken.
- R3: Single-flag tests use codes 0..7, and an even code is taken when its flag is 1 while the odd code one above it is taken when that flag is 0. Code 0/1 tests sign (flag bit 3), 2/3 tests zero (bit 2), 4/5 tests overflow (bit 1) and 6/7 tests carry (bit 0).
- R4: Code 8 (unsigned below-or-equal) is taken when (C OR Z)=1. Code 9 (unsigned above) is taken when (C OR Z)=0.
- R5: Code 10 (signed less) is taken when (S XOR O)=1. Code 11 (signed greater-or-equal) is taken when (S XOR O)=0.
- R6: Code 12 (signed less-or-equal) is taken when (Z OR (S XOR O))=1. Code 13 (signed greater) is taken when that expression is 0.
- R7: Code 14 is always taken and code 15 is never taken, whatever the flags.
- R8: `out_next_ip` equals the request's target when `out_taken`=1 and its fall-through address otherwise.
- R9: Codes 0..15 never assert `out_count_we`, and `out_count` equals the request's count unchanged.
- R10: Code 16 (plain loop) asserts `out_count_we` and outputs count-1 modulo 2^CW. It is taken when that new count is nonzero. A count of 0 wraps to all ones and is taken, and a count of 1 gives 0 and is not taken.
- R11: Code 17 (loop while zero) decrements like code 16 and is taken only if the new count is nonzero and Z=1. Code 18 (loop while not zero) decrements like code 16 and is taken only if the new count is nonzero and Z=0.
- R12: Codes 19..31 are not taken, output the fall-through address, do not assert `out_count_we`, and pass the count through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this edge if in_valid |
| in_op | input | 5 | Operation code (R3..R12) |
| in_flags | input | 4 | {S, Z, O, C} |
| in_count | input | CW (32) | Current count register value |
| in_target | input | AW (32) | Branch target address |
| in_fall | input | AW (32) | Fall-through address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_taken | output | 1 | Transfer taken |
| out_next_ip | output | AW (32) | Next instruction pointer |
| out_count | output | CW (32) | Count value to write back |
| out_count_we | output | 1 | Count register write-enable |

## Verification
The hardest behaviour to reach is the pair of count edges in the loop forms. In one, a zero count wraps to all ones and still branches. In the other, a count of one lands on zero and falls through, and for the zero-qualified loops this edge overlaps with the zero flag. The bench reaches both by feeding those count values directly on the count input. It does so for every operation code and every one of the sixteen flag patterns, and it includes the mid-range values 2 and 2^31. Back-pressure is reached by holding `out_ready` low for several cycles while a second request waits at the input.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int OP_W      = 5;
  localparam int FLAG_W    = 4;
  localparam int JUMP_LAST = 15;

  // flag bit positions inside the request's flag vector
  localparam int FB_C = 0;
  localparam int FB_O = 1;
  localparam int FB_Z = 2;
  localparam int FB_S = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOOP    = 5'd16,
    OP_LOOP_Z  = 5'd17,
    OP_LOOP_NZ = 5'd18
  } loop_op_e;

  // base conditions selected by op[3:1]; op[0] inverts
  typedef enum logic [2:0] {
    BC_SIGN  = 3'd0,
    BC_ZERO  = 3'd1,
    BC_OVF   = 3'd2,
    BC_CARRY = 3'd3,
    BC_ULE   = 3'd4,
    BC_SLT   = 3'd5,
    BC_SLE   = 3'd6,
    BC_ONE   = 3'd7
  } base_cond_e;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic [3:0]        sel,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);
  logic s_f, z_f, o_f, c_f;
  logic base;

  assign s_f = flags[FB_S];
  assign z_f = flags[FB_Z];
  assign o_f = flags[FB_O];
  assign c_f = flags[FB_C];

  always_comb begin
    unique case (base_cond_e'(sel[3:1]))
      BC_SIGN:  base = s_f;
      BC_ZERO:  base = z_f;
      BC_OVF:   base = o_f;
      BC_CARRY: base = c_f;
      BC_ULE:   base = c_f | z_f;
      BC_SLT:   base = s_f ^ o_f;
      BC_SLE:   base = z_f | (s_f ^ o_f);
      default:  base = 1'b1;
    endcase
  end

  assign hit = base ^ sel[0];

  // each complementary pair splits exactly: code 14 always true (R7)
  always_comb begin
    if (sel == 4'd14) assert_always_code_R7: assert (hit);
    if (sel == 4'd15) assert_never_code_R7: assert (!hit);
  end
endmodule

// File: rtl/br_loop_eval.sv
module br_loop_eval
  import br_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [FLAG_W-1:0] flags,
  input  logic [CW-1:0]     count,
  output logic              is_loop,
  output logic              hit,
  output logic [CW-1:0]     new_count
);
  logic [CW-1:0] dec;
  logic          nz;

  assign dec = count - CW'(1);
  assign nz  = |dec;

  always_comb begin
    is_loop = 1'b1;
    hit     = 1'b0;
    unique case (op)
      OP_LOOP:    hit = nz;
      OP_LOOP_Z:  hit = nz &  flags[FB_Z];
      OP_LOOP_NZ: hit = nz & ~flags[FB_Z];
      default:    is_loop = 1'b0;
    endcase
  end

  assign new_count = is_loop ? dec : count;

  // a taken loop never leaves a zero count behind (R10)
  always_comb begin
    if (hit) assert_loop_nonzero_R10: assert (new_count != '0);
    if (!is_loop) assert_count_passthru_R12: assert (new_count == count);
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [CW-1:0]     in_count,
  input  logic [AW-1:0]     in_target,
  input  logic [AW-1:0]     in_fall,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [AW-1:0]     out_next_ip,
  output logic [CW-1:0]     out_count,
  output logic              out_count_we
);
  localparam logic [OP_W-1:0] JUMP_MAX = OP_W'(JUMP_LAST);

  logic          is_jump;
  logic          cond_hit;
  logic          loop_sel, loop_hit;
  logic [CW-1:0] loop_count;
  logic          take_d;
  logic          accept;
  logic [OP_W-1:0] op_q;

  assign is_jump = (in_op <= JUMP_MAX);

  br_cond_eval u_cond (
    .sel   (in_op[3:0]),
    .flags (in_flags),
    .hit   (cond_hit)
  );

  br_loop_eval #(.CW(CW)) u_loop (
    .op        (in_op),
    .flags     (in_flags),
    .count     (in_count),
    .is_loop   (loop_sel),
    .hit       (loop_hit),
    .new_count (loop_count)
  );

  assign take_d   = is_jump ? cond_hit : loop_hit;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_next_ip  <= '0;
      out_count    <= '0;
      out_count_we <= 1'b0;
      op_q         <= '0;
    end else begin
      if (accept) begin
        out_valid    <= 1'b1;
        out_taken    <= take_d;
        out_next_ip  <= take_d ? in_target : in_fall;
        out_count    <= loop_count;
        out_count_we <= loop_sel;
        op_q         <= in_op;
      end else if (out_ready) begin
        out_valid    <= 1'b0;
      end
    end
  end

  assert_empty_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_ip) &&
      $stable(out_taken) && $stable(out_count) && $stable(out_count_we)));

  assert_jump_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q <= JUMP_MAX) |-> !out_count_we);

  assert_bad_op_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q > OP_W'(OP_LOOP_NZ)) |-> (!out_taken && !out_count_we));
endmodule

// File: tb/br_resolve_bench.sv
`timescale 1ns/1ps
module br_resolve_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [3:0]  in_flags = '0;
  logic [31:0] in_count = '0;
  logic [31:0] in_target = '0;
  logic [31:0] in_fall = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic [31:0] out_next_ip;
  logic [31:0] out_count;
  logic        out_count_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  br_resolve u_br_resolve (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op < 8)  return "R3";
    if (op < 10) return "R4";
    if (op < 12) return "R5";
    if (op < 14) return "R6";
    if (op < 16) return "R7";
    if (op == 16) return "R10";
    if (op < 19) return "R11";
    return "R12";
  endfunction

  // reference computed from the requirement text
  task automatic model(input int op, input logic [3:0] f, input logic [31:0] cnt,
                       output logic tk, output logic we, output logic [31:0] nc);
    logic s, z, o, c;
    logic [32:0] wide;
    s = f[3]; z = f[2]; o = f[1]; c = f[0];
    wide = {1'b0, cnt} + 33'h1_FFFF_FFFF;
    tk = 1'b0; we = 1'b0; nc = cnt;
    case (op)
      0: tk = s;   1: tk = !s;
      2: tk = z;   3: tk = !z;
      4: tk = o;   5: tk = !o;
      6: tk = c;   7: tk = !c;
      8: tk = (c || z);         9: tk = !(c || z);
      10: tk = (s != o);        11: tk = (s == o);
      12: tk = z || (s != o);   13: tk = !(z || (s != o));
      14: tk = 1'b1;            15: tk = 1'b0;
      16, 17, 18: begin
        we = 1'b1;
        nc = wide[31:0];
        tk = (nc != 32'd0);
        if (op == 17) tk = tk && z;
        if (op == 18) tk = tk && !z;
      end
      default: ;
    endcase
  endtask

  task automatic run_one(input int op, input logic [3:0] f, input logic [31:0] cnt);
    logic tk, we;
    logic [31:0] nc, tgt, fl;
    string r;
    tgt = 32'hA000_0000 ^ {op[7:0], 4'h0, f, cnt[15:0]};
    fl  = 32'h0000_4000 + 32'(op * 16 + int'(f));
    @(negedge clk);
    in_op = op[4:0]; in_flags = f; in_count = cnt;
    in_target = tgt; in_fall = fl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(op, f, cnt, tk, we, nc);
    r = req_of(op);
    check("R2", "out_valid", 32'(out_valid), 32'd1);
    check(r, $sformatf("taken op=%0d f=%h c=%h", op, f, cnt), 32'(out_taken), 32'(tk));
    check("R8", "next_ip", out_next_ip, tk ? tgt : fl);
    check((op < 16) ? "R9" : r, "count_we", 32'(out_count_we), 32'(we));
    check((op < 16) ? "R9" : r, "count", out_count, nc);
  endtask

  initial begin
    logic [31:0] corners [5];
    logic [31:0] hold_ip;
    corners[0] = 32'd0; corners[1] = 32'd1; corners[2] = 32'd2;
    corners[3] = 32'h8000_0000; corners[4] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check("R1", "in_ready after reset", 32'(in_ready), 32'd1);

    for (int op = 0; op < 32; op++)
      for (int f = 0; f < 16; f++)
        for (int k = 0; k < 5; k++)
          run_one(op, 4'(f), corners[k]);

    // explicit R10 edges
    run_one(16, 4'h0, 32'd0);
    check("R10", "wrap count", out_count, 32'hFFFF_FFFF);
    check("R10", "wrap taken", 32'(out_taken), 32'd1);
    run_one(16, 4'h0, 32'd1);
    check("R10", "one gives zero not taken", 32'(out_taken), 32'd0);

    // back-pressure (R2)
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 5'd14; in_flags = 4'h0; in_count = 32'd5;
    in_target = 32'h1111_0000; in_fall = 32'h2222_0000; in_valid = 1'b1;
    @(negedge clk);
    in_op = 5'd15; in_target = 32'h3333_0000; in_fall = 32'h4444_0000;
    hold_ip = out_next_ip;
    check("R2", "first result", hold_ip, 32'h1111_0000);
    repeat (4) begin
      @(negedge clk);
      check("R2", "stall valid", 32'(out_valid), 32'd1);
      check("R2", "stall in_ready", 32'(in_ready), 32'd0);
      check("R2", "stall hold ip", out_next_ip, hold_ip);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "second result after release", out_next_ip, 32'h4444_0000);
    check("R7", "code 15 not taken", 32'(out_taken), 32'd0);
    @(negedge clk);
    check("R2", "drained", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule